// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Control

This block is the hazard controller for a five-stage in-order pipeline that resolves conditional branches in the decode stage. The branch condition is an equality test of two registers. The target is computed in decode as well. Each cycle, the block looks at the two source register numbers of a branch sitting in decode. It compares them with the destination registers of the instructions now in execute, memory and writeback.

For each source it decides one of three things. The comparator can take the value forwarded from a later stage. The comparator can read the register file. Or the branch must wait. While the branch waits, the block asserts a stall: the PC and the fetch/decode register hold their values, and a bubble enters the decode/execute register. Branches are predicted not taken. When the comparator reports equality in a cycle with no stall, the block asserts a flush. The flush turns the instruction fetched behind the branch into a bubble by zeroing its control signals.

The result is a stall count that depends on the kind of producer and its distance from the branch:
- An ALU producer two or three slots ahead costs nothing.
- An ALU producer directly ahead costs one cycle.
- A load two slots ahead costs one cycle.
- A load directly ahead costs two cycles.

Top module: `id_branch_hazard`

## Requirements
- R1: When no branch is in decode (`id_branch`=0), `stall` and `flush` are 0 and both forwarding selects are 2'b00 (register file).
- R2: A branch stalls when either of its source registers matches the destination of a register-writing instruction in execute. This holds whether that instruction is an ALU operation or a load.
- R3: A branch stalls when a source matches the destination of a load in the memory stage and no instruction in execute writes that register.
- R4: Suppose a source matches a register-writing non-load instruction in the memory stage, and the branch is not stalled. Then that source's select is 2'b01 (value from the execute/memory register).
- R5: Suppose a source matches a register-writing instruction in writeback, no younger stage writes it, and the branch is not stalled. Then the select is 2'b10 (value from the memory/writeback register).
- R6: When the memory and writeback stages both write a source register, the select takes the younger producer (2'b01). The value 2'b11 never appears.
- R7: Register 0 never causes a stall or a forward. An instruction whose register-write flag is clear never causes a stall or a forward.
- R8: `flush` equals branch-in-decode AND `id_equal` AND NOT `stall`. While `stall` is high, `flush` is 0 and both selects are 2'b00.
- R9: In a running pipeline, the cycles a branch waits in decode are:
  - one after an ALU producer directly ahead;
  - one after a load two slots ahead;
  - two after a load directly ahead;
  - none after an ALU producer two or three slots ahead.

  The block never stalls three cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_branch | input | 1 | A conditional branch occupies decode |
| id_rs | input | REG_W | First branch source register |
| id_rt | input | REG_W | Second branch source register |
| id_equal | input | 1 | Decode comparator reports equal operands (branch taken) |
| ex_rd | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| stall | output | 1 | Hold PC and fetch/decode; bubble into decode/execute |
| flush | output | 1 | Squash the instruction fetched behind a taken branch |
| fwd_a | output | 2 | Comparator source for `id_rs`: 00 file, 01 memory stage, 10 writeback |
| fwd_b | output | 2 | Comparator source for `id_rt`, same encoding |

## Verification
The bench models a pipeline that moves instructions, inserts bubbles on stalls and squashes the fetched instruction on flushes. Expected outputs are computed each cycle from that model.

Directed traces cover the cases that separate the stall counts:
- A load directly ahead of the branch. A design that counts only one stall here would compare a stale value.
- A load two slots ahead.
- ALU producers at distance one, two and three.

Further directed traces cover three more corners:
- Two producers of the same register in memory and writeback. Picking the older one forwards an outdated value.
- Register 0 as a destination. Treating it as a hazard adds needless stall cycles.
- A taken branch. Flushing during a stall would discard the branch's own successor too early.

// File: rtl/bhu_pkg.sv
package bhu_pkg;
    localparam int REG_W_DEF = 5;
    localparam int RUN_W     = 2;
    localparam int NSRC      = 2;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } bhu_state_t;
endpackage

// File: rtl/bhu_src_match.sv
module bhu_src_match
    import bhu_pkg::*;
#(
    parameter int REG_W = REG_W_DEF
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr,
    input  logic             mem_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr,
    output logic             hold,
    output logic [1:0]       sel
);
    logic live, hit_ex, hit_mem, hit_wb;

    always_comb begin
        live    = (src != '0);
        hit_ex  = live && ex_wr  && (ex_rd  == src);
        hit_mem = live && mem_wr && (mem_rd == src);
        hit_wb  = live && wb_wr  && (wb_rd  == src);
        // value not yet available: producer in EX, or a load still in MEM
        hold    = hit_ex || (hit_mem && mem_load);
        // youngest producer first
        if (hit_mem)     sel = FWD_MEM;
        else if (hit_wb) sel = FWD_WB;
        else             sel = FWD_RF;
    end
endmodule

// File: rtl/id_branch_hazard.sv
module id_branch_hazard
    import bhu_pkg::*;
#(
    parameter int REG_W = REG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_branch,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_equal,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr,
    input  logic             mem_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr,
    output logic             stall,
    output logic             flush,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [REG_W-1:0] src_w  [NSRC];
    logic             hold_w [NSRC];
    logic [1:0]       sel_w  [NSRC];

    assign src_w[0] = id_rs;
    assign src_w[1] = id_rt;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        bhu_src_match #(.REG_W(REG_W)) u_match (
            .src      (src_w[g]),
            .ex_rd    (ex_rd),
            .ex_wr    (ex_wr),
            .mem_rd   (mem_rd),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .wb_rd    (wb_rd),
            .wb_wr    (wb_wr),
            .hold     (hold_w[g]),
            .sel      (sel_w[g])
        );
    end

    bhu_state_t st_d, st_q;
    logic       go;

    always_comb begin
        stall = id_branch && (hold_w[0] || hold_w[1]);
        go    = id_branch && !stall;
        flush = go && id_equal;
        fwd_a = go ? sel_w[0] : FWD_RF;
        fwd_b = go ? sel_w[1] : FWD_RF;
        st_d  = st_q;
        if (!stall)               st_d.run = '0;
        else if (st_q.run != RUN_MAX) st_d.run = st_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // idle decode: nothing requested
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !id_branch |-> (!stall && !flush && fwd_a == 2'b00 && fwd_b == 2'b00));

    // register 0 on both sources never waits
    p_zero_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0 && id_rt == '0) |-> !stall);

    // stalling branch neither flushes nor forwards
    p_stall_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!flush && fwd_a == 2'b00 && fwd_b == 2'b00));

    // select encoding stays legal
    p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11 && fwd_b != 2'b11));

    // two waits at most, then the branch resolves
    p_stall_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run >= 2) |-> !stall);
endmodule

// File: tb/sim_id_branch_hazard.sv
`timescale 1ns/1ps
module sim_id_branch_hazard;
    localparam int RW = 5;

    typedef struct packed {
        logic          br;
        logic          wr;
        logic          ld;
        logic          eq;
        logic [RW-1:0] rd;
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    ins_t id_s, ex_s, mem_s, wb_s;
    ins_t tr [0:63];
    int   tr_n, pc;

    logic       stall, flush;
    logic [1:0] fwd_a, fwd_b;

    id_branch_hazard #(.REG_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .id_branch(id_s.br), .id_rs(id_s.rs), .id_rt(id_s.rt), .id_equal(id_s.eq),
        .ex_rd(ex_s.rd), .ex_wr(ex_s.wr),
        .mem_rd(mem_s.rd), .mem_wr(mem_s.wr), .mem_load(mem_s.ld),
        .wb_rd(wb_s.rd), .wb_wr(wb_s.wr),
        .stall(stall), .flush(flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    int vectors = 0, bad = 0, stall_seen = 0;
    bit done = 0;

    // {needs_wait, select} for one source, scanning producers youngest first
    function automatic logic [2:0] src_need(logic [RW-1:0] s, ins_t e, ins_t m, ins_t w);
        ins_t older [3];
        older[0] = e; older[1] = m; older[2] = w;
        if (s == 0) return 3'b000;
        for (int d = 0; d < 3; d++) begin
            if (older[d].wr && older[d].rd == s) begin
                if (d == 0) return 3'b100;
                if (d == 1) return older[d].ld ? 3'b100 : 3'b001;
                return 3'b010;
            end
        end
        return 3'b000;
    endfunction

    function automatic ins_t mk(bit br, bit wr, bit ld, bit eq, int rd, int rs, int rt);
        ins_t i;
        i.br = br; i.wr = wr; i.ld = ld; i.eq = eq;
        i.rd = RW'(rd); i.rs = RW'(rs); i.rt = RW'(rt);
        return i;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_trace();
        logic [2:0] a, b;
        bit   e_st, e_fl;
        logic [1:0] e_fa, e_fb;
        string tag;
        int guard = 0;
        stall_seen = 0;
        pc = 0;
        id_s = '0; ex_s = '0; mem_s = '0; wb_s = '0;
        while ((pc < tr_n || id_s != '0 || ex_s != '0 || mem_s != '0) && guard < 400) begin
            guard++;
            @(negedge clk); #1;
            a = src_need(id_s.rs, ex_s, mem_s, wb_s);
            b = src_need(id_s.rt, ex_s, mem_s, wb_s);
            e_st = id_s.br && (a[2] || b[2]);
            e_fl = id_s.br && !e_st && id_s.eq;
            e_fa = (id_s.br && !e_st) ? a[1:0] : 2'b00;
            e_fb = (id_s.br && !e_st) ? b[1:0] : 2'b00;
            if (!id_s.br) tag = "R1";
            else if (e_st) tag = ex_s.wr ? "R2" : "R3";
            else if (e_fa == 2'b01 && a[1:0] == 2'b01 && wb_s.wr && wb_s.rd == id_s.rs) tag = "R6";
            else if (e_fa == 2'b01 || e_fb == 2'b01) tag = "R4";
            else if (e_fa == 2'b10 || e_fb == 2'b10) tag = "R5";
            else tag = "R7";
            cmp(tag, "stall", stall, e_st);
            cmp("R8", "flush", flush, e_fl);
            cmp(tag, "fwd_a", fwd_a, e_fa);
            cmp(tag, "fwd_b", fwd_b, e_fb);
            if (stall) stall_seen++;
            @(posedge clk); #1;
            wb_s = mem_s; mem_s = ex_s;
            if (e_st) ex_s = '0;
            else begin
                ex_s = id_s;
                if (pc < tr_n) begin id_s = e_fl ? '0 : tr[pc]; pc++; end
                else id_s = '0;
            end
        end
    endtask

    task automatic directed(string tag, int exp_stalls);
        run_trace();
        cmp(tag, "stall cycles", stall_seen, exp_stalls);
    endtask

    initial begin
        id_s = '0; ex_s = '0; mem_s = '0; wb_s = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1", "reset stall", stall, 0);
        cmp("R1", "reset flush", flush, 0);
        rst_n = 1'b1;

        // R9: ALU directly ahead -> one wait
        tr[0] = mk(0,1,0,0,1,0,0); tr[1] = mk(1,0,0,0,0,1,2); tr_n = 2;
        directed("R9", 1);
        // R9: load two slots ahead -> one wait
        tr[0] = mk(0,1,1,0,1,0,0); tr[1] = '0; tr[2] = mk(1,0,0,0,0,1,0); tr_n = 3;
        directed("R9", 1);
        // R9: load directly ahead -> two waits
        tr[0] = mk(0,1,1,0,1,0,0); tr[1] = mk(1,0,0,0,0,1,0); tr_n = 2;
        directed("R9", 2);
        // R4: ALU two ahead forwards from MEM
        tr[0] = mk(0,1,0,0,1,0,0); tr[1] = '0; tr[2] = mk(1,0,0,0,0,1,2); tr_n = 3;
        directed("R4", 0);
        // R5: ALU three ahead forwards from WB
        tr[0] = mk(0,1,0,0,1,0,0); tr[1] = '0; tr[2] = '0; tr[3] = mk(1,0,0,0,0,2,1); tr_n = 4;
        directed("R5", 0);
        // R7: register 0 destination never waits
        tr[0] = mk(0,1,1,0,0,0,0); tr[1] = mk(1,0,0,0,0,0,0); tr_n = 2;
        directed("R7", 0);
        // R7: non-writing producer never waits
        tr[0] = mk(0,0,0,0,3,0,0); tr[1] = mk(1,0,0,0,0,3,3); tr_n = 2;
        directed("R7", 0);
        // R6: two producers of r3, youngest wins
        tr[0] = mk(0,1,0,0,3,0,0); tr[1] = mk(0,1,0,0,3,0,0); tr[2] = '0;
        tr[3] = mk(1,0,0,0,0,3,0); tr_n = 4;
        directed("R6", 0);
        // R8: taken branch squashes next fetch (ALU r6 never enters EX)
        tr[0] = mk(1,0,0,1,0,4,5); tr[1] = mk(0,1,0,0,6,0,0);
        tr[2] = mk(1,0,0,0,0,6,0); tr_n = 3;
        directed("R8", 0);
        // R8: taken branch behind a load directly ahead still waits twice first
        tr[0] = mk(0,1,1,0,2,0,0); tr[1] = mk(1,0,0,1,0,2,2); tr_n = 2;
        directed("R8", 2);

        void'($urandom(32'd1234));
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < 48; k++) begin
                int kind = $urandom % 20;
                int r1 = $urandom % 4, r2 = $urandom % 4, r3 = $urandom % 4;
                if (kind < 5)       tr[k] = mk(1,0,0,$urandom%2,0,r2,r3);
                else if (kind < 10) tr[k] = mk(0,1,1,0,r1,0,0);
                else if (kind < 16) tr[k] = mk(0,1,0,0,r1,0,0);
                else                tr[k] = '0;
            end
            tr_n = 48;
            run_trace();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; bad++;
            $display("FAIL watchdog actual=expired expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end
endmodule